// File: doc/BRIEF.md
# DMA Completion and Error Reporter

This block sits beside a DMA engine and turns its raw end-of-transfer and fault events into the signals the rest of the chip consumes. Each completion arrives as a one-cycle pulse with a channel number. If the channel belongs to a peripheral, a one-cycle done pulse goes to that peripheral. If the channel is marked as dedicated to software, a software completion interrupt pulse is raised instead. The channel decides the routing. Who started the transfer makes no difference, so a software-started transfer on a peripheral channel still ends on that peripheral's done line.

A bus or protection fault also arrives as a pulse with a channel number. The block then sends a one-cycle disable pulse to that channel and sets a sticky error flag. The flag drives a level-sensitive error interrupt. The number of the first faulting channel is captured next to the flag and is held until software clears the flag by writing 1 to bit 0 of the register port. Every output is registered and appears one clock after the event that causes it.

Top module: `dma_event_router`

## Requirements
- R1: A completion on a channel whose bit in `sw_chan_mask` is 0 produces `done_vec` with only that channel's bit set, for exactly one cycle, on the cycle after the completion pulse.
- R2: A completion on a channel whose `sw_chan_mask` bit is 1 produces a one-cycle `sw_irq` pulse on the next cycle and leaves `done_vec` all zero.
- R3: An error pulse produces `ch_disable` with only the faulting channel's bit set, for one cycle, on the next cycle. This happens whether or not the flag is already set.
- R4: An error sets the error flag, read as `reg_rdata` bit 0, on the next cycle. `err_irq` equals that flag on every cycle.
- R5: A register write with `reg_wdata` bit 0 = 1 clears the flag and the stored channel on the next cycle. A write with bit 0 = 0 changes neither.
- R6: If an error and a clearing write occur in the same cycle, the flag stays set and the stored channel is kept.
- R7: The channel number of the error that sets the flag is shown in `reg_rdata[8 +: CH_W]`. Later errors do not change it while the flag is set. The other bits of `reg_rdata` read as 0.
- R8: If a completion and an error name the same channel in the same cycle, neither a done pulse nor `sw_irq` is produced. If they name different channels, both take effect.
- R9: After synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_vld | input | 1 | Transfer-complete pulse |
| cmpl_ch | input | CH_W | Channel of the completion |
| err_vld | input | 1 | Bus/protection error pulse |
| err_ch | input | CH_W | Channel that faulted |
| sw_chan_mask | input | NUM_CH | 1 = channel is software-dedicated |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | DATA_W | Write data; bit 0 = 1 clears the error |
| reg_rdata | output | DATA_W | Status: bit 0 flag, bits 8+ first faulting channel |
| done_vec | output | NUM_CH | Per-channel done pulses to peripherals |
| sw_irq | output | 1 | Software completion interrupt pulse |
| err_irq | output | 1 | Error interrupt, level |
| ch_disable | output | NUM_CH | Per-channel disable pulses |

## Verification
Some rules can be checked on every cycle. The assertions confirm that `err_irq` matches the status flag and that done pulses are at most one-hot. They also check that each error gives a one-hot disable on its own channel, that a same-channel collision suppresses completion, and that the stored channel stays fixed while the flag is held. Other behaviour only appears across a sequence of events, and the bench's scenarios cover it. This includes the choice between `done_vec` and `sw_irq` under a given mask, the first-error capture followed by later errors, and a clear arriving together with a new error. It also includes a write with bit 0 = 0 that must change nothing.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  // Status register layout seen at reg_rdata
  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_CHAN_LSB = 8;
  // Write data bit that clears the error
  localparam int unsigned CLR_BIT       = 0;
endpackage

// File: rtl/dma_evt_onehot.sv
module dma_evt_onehot #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              vld,
  input  logic [CH_W-1:0]   idx,
  output logic [NUM_CH-1:0] hot
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign hot[g] = vld && (idx == CH_W'(g));
  end
endmodule

// File: rtl/dma_done_router.sv
module dma_done_router #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmpl_hot,
  input  logic [NUM_CH-1:0] err_hot,
  input  logic [NUM_CH-1:0] sw_mask,
  output logic [NUM_CH-1:0] done_vec,
  output logic              sw_irq
);
  logic [NUM_CH-1:0] live;
  logic [NUM_CH-1:0] periph_d;
  logic [NUM_CH-1:0] soft_d;

  // completion survives only when its channel did not fault this cycle
  assign live     = cmpl_hot & ~err_hot;
  assign periph_d = live & ~sw_mask;
  assign soft_d   = live & sw_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_vec <= '0;
      sw_irq   <= 1'b0;
    end else begin
      done_vec <= periph_d;
      sw_irq   <= |soft_d;
    end
  end
endmodule

// File: rtl/dma_err_tracker.sv
module dma_err_tracker #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_vld,
  input  logic [CH_W-1:0]   err_ch,
  input  logic [NUM_CH-1:0] err_hot,
  input  logic              clr,
  output logic [NUM_CH-1:0] ch_disable,
  output logic              flag,
  output logic [CH_W-1:0]   first_ch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_disable <= '0;
      flag       <= 1'b0;
      first_ch   <= '0;
    end else begin
      ch_disable <= err_hot;
      if (err_vld) begin
        flag <= 1'b1;
        if (!flag) first_ch <= err_ch;
      end else if (clr) begin
        flag     <= 1'b0;
        first_ch <= '0;
      end
    end
  end
endmodule

// File: rtl/dma_event_router.sv
module dma_event_router
  import dma_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpl_vld,
  input  logic [CH_W-1:0]   cmpl_ch,
  input  logic              err_vld,
  input  logic [CH_W-1:0]   err_ch,
  input  logic [NUM_CH-1:0] sw_chan_mask,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] done_vec,
  output logic              sw_irq,
  output logic              err_irq,
  output logic [NUM_CH-1:0] ch_disable
);
  logic [NUM_CH-1:0] cmpl_hot;
  logic [NUM_CH-1:0] err_hot;
  logic              flag;
  logic [CH_W-1:0]   first_ch;
  logic              clr;

  assign clr = reg_wr && reg_wdata[CLR_BIT];

  dma_evt_onehot #(.NUM_CH(NUM_CH)) u_cmpl_dec (
    .vld(cmpl_vld), .idx(cmpl_ch), .hot(cmpl_hot));

  dma_evt_onehot #(.NUM_CH(NUM_CH)) u_err_dec (
    .vld(err_vld), .idx(err_ch), .hot(err_hot));

  dma_done_router #(.NUM_CH(NUM_CH)) u_route (
    .clk(clk), .rst(rst), .cmpl_hot(cmpl_hot), .err_hot(err_hot),
    .sw_mask(sw_chan_mask), .done_vec(done_vec), .sw_irq(sw_irq));

  dma_err_tracker #(.NUM_CH(NUM_CH)) u_err (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_ch(err_ch),
    .err_hot(err_hot), .clr(clr), .ch_disable(ch_disable),
    .flag(flag), .first_ch(first_ch));

  always_comb begin
    reg_rdata = '0;
    reg_rdata[STAT_FLAG_BIT] = flag;
    reg_rdata[STAT_CHAN_LSB +: CH_W] = first_ch;
  end

  assign err_irq = flag;
endmodule

// File: rtl/dma_event_router_chk.sv
module dma_event_router_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmpl_vld,
  input logic [CH_W-1:0]   cmpl_ch,
  input logic              err_vld,
  input logic [CH_W-1:0]   err_ch,
  input logic [NUM_CH-1:0] sw_chan_mask,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_CH-1:0] done_vec,
  input logic              sw_irq,
  input logic              err_irq,
  input logic [NUM_CH-1:0] ch_disable
);
  p_irq_is_flag_r4: assert property (@(posedge clk) disable iff (rst)
    err_irq == reg_rdata[0]);

  p_done_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done_vec));

  p_done_route_r1: assert property (@(posedge clk) disable iff (rst)
    (cmpl_vld && !sw_chan_mask[cmpl_ch] && !(err_vld && err_ch == cmpl_ch))
      |=> done_vec[$past(cmpl_ch)]);

  p_disable_hit_r3: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> (ch_disable[$past(err_ch)] && $countones(ch_disable) == 1));

  p_err_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> err_irq);

  p_chan_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !(reg_wr && reg_wdata[0])) |=> $stable(reg_rdata[8 +: CH_W]));

  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    (cmpl_vld && err_vld && cmpl_ch == err_ch) |=> (done_vec == '0 && !sw_irq));
endmodule

bind dma_event_router dma_event_router_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_event_router_bench.sv
module dma_event_router_bench;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CH_W   = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmpl_vld, err_vld, reg_wr;
  logic [CH_W-1:0]   cmpl_ch, err_ch;
  logic [NUM_CH-1:0] sw_chan_mask;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic [NUM_CH-1:0] done_vec, ch_disable;
  logic              sw_irq, err_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_event_router #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dma_event_router (.*);

  typedef struct packed {
    logic       cv; logic [2:0] cc;
    logic       ev; logic [2:0] ec;
    logic       wr; logic       w0;
    logic [7:0] xdone; logic xsw; logic [7:0] xdis;
    logic       xflag; logic [2:0] xchan;
  } vec_t;

  // Software-dedicated channels: 0 and 7 (mask 8'h81)
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,3'd3, 1'b0,3'd0, 1'b0,1'b0, 8'h08,1'b0,8'h00, 1'b0,3'd0}, // R1
    '{1'b1,3'd0, 1'b0,3'd0, 1'b0,1'b0, 8'h00,1'b1,8'h00, 1'b0,3'd0}, // R2
    '{1'b1,3'd7, 1'b0,3'd0, 1'b0,1'b0, 8'h00,1'b1,8'h00, 1'b0,3'd0}, // R2
    '{1'b0,3'd0, 1'b0,3'd0, 1'b0,1'b0, 8'h00,1'b0,8'h00, 1'b0,3'd0}, // R1 pulse ends
    '{1'b0,3'd0, 1'b1,3'd5, 1'b0,1'b0, 8'h00,1'b0,8'h20, 1'b1,3'd5}, // R3 R4 R7
    '{1'b1,3'd6, 1'b1,3'd2, 1'b0,1'b0, 8'h40,1'b0,8'h04, 1'b1,3'd5}, // R7 R8
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b0, 8'h00,1'b0,8'h00, 1'b1,3'd5}, // R5 no-op write
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b1, 8'h00,1'b0,8'h00, 1'b0,3'd0}, // R5 clear
    '{1'b1,3'd4, 1'b1,3'd4, 1'b0,1'b0, 8'h00,1'b0,8'h10, 1'b1,3'd4}, // R8 collide
    '{1'b0,3'd0, 1'b1,3'd1, 1'b1,1'b1, 8'h00,1'b0,8'h02, 1'b1,3'd4}, // R6
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,1'b1, 8'h00,1'b0,8'h00, 1'b0,3'd0}, // R5
    '{1'b1,3'd7, 1'b1,3'd7, 1'b0,1'b0, 8'h00,1'b0,8'h80, 1'b1,3'd7}, // R8 sw collide
    '{1'b1,3'd0, 1'b1,3'd3, 1'b0,1'b0, 8'h00,1'b1,8'h08, 1'b1,3'd7}  // R8 R2
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cmpl_vld = 0; cmpl_ch = '0; err_vld = 0; err_ch = '0;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic check_zero(input string req);
    chk(req, "done_vec", 32'(done_vec), 0);
    chk(req, "sw_irq", 32'(sw_irq), 0);
    chk(req, "err_irq", 32'(err_irq), 0);
    chk(req, "ch_disable", 32'(ch_disable), 0);
    chk(req, "reg_rdata", reg_rdata, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    sw_chan_mask = 8'h81;
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check_zero("R9");

    for (int i = 0; i < NV; i++) begin
      cmpl_vld = VECS[i].cv; cmpl_ch = VECS[i].cc;
      err_vld  = VECS[i].ev; err_ch  = VECS[i].ec;
      reg_wr   = VECS[i].wr; reg_wdata = {31'b0, VECS[i].w0};
      @(negedge clk);
      chk("R1/R8", "done_vec", 32'(done_vec), 32'(VECS[i].xdone));
      chk("R2/R8", "sw_irq", 32'(sw_irq), 32'(VECS[i].xsw));
      chk("R3", "ch_disable", 32'(ch_disable), 32'(VECS[i].xdis));
      chk("R4/R5/R6", "flag", 32'(reg_rdata[0]), 32'(VECS[i].xflag));
      chk("R4", "err_irq", 32'(err_irq), 32'(VECS[i].xflag));
      chk("R7", "first_ch", 32'(reg_rdata[8 +: 3]), 32'(VECS[i].xchan));
      chk("R7", "unused bits", reg_rdata & ~32'h0000_0701, 0);
    end

    // R1: done pulse lasts a single cycle
    idle();
    @(negedge clk);
    chk("R1", "done after idle", 32'(done_vec), 0);
    chk("R3", "disable after idle", 32'(ch_disable), 0);

    // R2: changing the mask reroutes channel 3 to the software interrupt
    sw_chan_mask = 8'h08;
    cmpl_vld = 1; cmpl_ch = 3'd3;
    @(negedge clk);
    idle();
    chk("R2", "remapped sw_irq", 32'(sw_irq), 1);
    chk("R2", "remapped done", 32'(done_vec), 0);

    // R9: reset while an error is held
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check_zero("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule